// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block is a hardware master that fetches one 16-bit word from a three-wire serial EEPROM of the Microwire kind. It drives chip select, serial clock and serial data toward the memory, and it takes the memory's serial data output back in through a two-flop synchronizer. A one-cycle request carries an 8-bit word address. The block then plays a fixed list of pin states and returns the word with a one-cycle done pulse.

Every pin state is held for `HOLD_CYCLES` system clocks before the next one is applied, so the serial timing follows the memory's minimum hold time at any system clock rate. The sequence has four parts. First comes a dummy clock. Then the command is sent: a start bit, the two-bit READ opcode and the address. Sixteen clocked read cycles follow, and a fixed teardown ends the sequence. The word is shifted in MSB first and presented as it arrived. While a read is running, further requests are ignored. READ is the only command this block issues.

Top module: `mw_word_reader`

## Requirements
- R1: After reset and whenever no read is running, `ee_cs_o`, `ee_sk_o` and `ee_di_o` are low, `busy_o` and `done_o` are low, and `data_o` keeps its value (zero after reset).
- R2: Each pin state of a read is held for exactly `HOLD_CYCLES` clocks. The first state (all pins low) begins at the clock edge that accepts the request, and the pin state for step k appears k*`HOLD_CYCLES` edges later.
- R3: A read opens with all pins low, then cs alone, then cs with sk, then cs alone (a dummy clock).
- R4: Next come the start bit and the READ opcode 1,0. Each of the three bits is placed on `ee_di_o` with sk low and cs high, and is then clocked by raising sk. `ee_di_o` is never high while cs is low.
- R5: The 8 address bits follow MSB first, each bit first with sk low and then with sk high. `ee_di_o` does not change while sk stays high.
- R6: After the address, the pins return to cs high with sk and di low for one hold interval.
- R7: Sixteen read cycles follow, each one cs with sk high and then cs alone. The synchronized data line is sampled at the end of each low interval. `data_o` is the sixteen samples with the first sample in bit 15, with no byte swap.
- R8: Teardown is all low, then cs alone, then all low, then sk alone. After that the pins return to all low.
- R9: `busy_o` is high from the clock after an accepted request until `done_o`. `done_o` is a one-cycle pulse, 63*`HOLD_CYCLES` edges after the accepting edge, in the same cycle that `busy_o` falls.
- R10: A request while `busy_o` is high is ignored. The running read keeps its address, its pin sequence and its result, and no second read follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start a read (taken when idle) |
| addr_i | input | ADDR_W (8) | Word address, captured with the request |
| busy_o | output | 1 | Read in progress |
| done_o | output | 1 | One-cycle pulse, data_o valid |
| data_o | output | DATA_W (16) | Word read, first bit in the MSB |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | EEPROM serial data input (from master) |
| ee_do_i | input | 1 | EEPROM serial data output (to master) |

## Verification
The hold-time and pin-order properties assume that `HOLD_CYCLES` is at least 3. With a shorter hold, the two synchronizer flops would sample the data line before it settles. The bench uses a hold of 4 clocks. Its behavioural EEPROM changes its data line only right after a rising serial clock with chip select high, so the line is stable across the whole read low interval. The assertions also take the request to be a plain level that is sampled on each edge. The bench drives it for one cycle at a time, away from the clock edge. It does this both when the block is idle and in the middle of a read.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mw_state_e;

    typedef struct packed {
        logic cs;
        logic sk;
        logic di;
    } mw_pins_t;

endpackage

// File: rtl/mw_hold_timer.sv
module mw_hold_timer #(
    parameter int HOLD_CYCLES = 50
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    output logic expire_o
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = RELOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/mw_sync2.sv
module mw_sync2 (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign q_o = sync_q[1];
endmodule

// File: rtl/mw_step_decode.sv
module mw_step_decode
    import mw_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int STEP_W = 6
) (
    input  logic [STEP_W-1:0] step_i,
    input  logic [ADDR_W-1:0] addr_i,
    output mw_pins_t          pins_o,
    output logic              sample_o
);
    // step map: 0..9 preamble/command, address pairs, one settle step,
    // read pairs, four teardown steps
    localparam logic [STEP_W-1:0] S_ADDR   = STEP_W'(10);
    localparam logic [STEP_W-1:0] S_SETTLE = STEP_W'(10 + 2 * ADDR_W);
    localparam logic [STEP_W-1:0] S_READ   = STEP_W'(11 + 2 * ADDR_W);
    localparam logic [STEP_W-1:0] S_TEAR   = STEP_W'(11 + 2 * ADDR_W + 2 * DATA_W);

    logic [STEP_W-1:0] off;
    logic [ADDR_W-1:0] addr_sh;

    always_comb begin
        pins_o   = '0;
        sample_o = 1'b0;
        off      = '0;
        addr_sh  = '0;
        if (step_i < S_ADDR) begin
            case (step_i[3:0])
                4'd1:    pins_o = '{cs: 1'b1, sk: 1'b0, di: 1'b0};
                4'd2:    pins_o = '{cs: 1'b1, sk: 1'b1, di: 1'b0};
                4'd3:    pins_o = '{cs: 1'b1, sk: 1'b0, di: 1'b0};
                4'd4:    pins_o = '{cs: 1'b1, sk: 1'b0, di: 1'b1};
                4'd5:    pins_o = '{cs: 1'b1, sk: 1'b1, di: 1'b1};
                4'd6:    pins_o = '{cs: 1'b1, sk: 1'b0, di: 1'b1};
                4'd7:    pins_o = '{cs: 1'b1, sk: 1'b1, di: 1'b1};
                4'd8:    pins_o = '{cs: 1'b1, sk: 1'b0, di: 1'b0};
                4'd9:    pins_o = '{cs: 1'b1, sk: 1'b1, di: 1'b0};
                default: pins_o = '0;
            endcase
        end else if (step_i < S_SETTLE) begin
            off       = step_i - S_ADDR;
            addr_sh   = addr_i << (off >> 1);
            pins_o.cs = 1'b1;
            pins_o.di = addr_sh[ADDR_W-1];
            pins_o.sk = off[0];
        end else if (step_i == S_SETTLE) begin
            pins_o.cs = 1'b1;
        end else if (step_i < S_TEAR) begin
            off       = step_i - S_READ;
            pins_o.cs = 1'b1;
            pins_o.sk = ~off[0];
            sample_o  = off[0];
        end else begin
            off = step_i - S_TEAR;
            case (off[1:0])
                2'd1:    pins_o.cs = 1'b1;
                2'd3:    pins_o.sk = 1'b1;
                default: pins_o    = '0;
            endcase
        end
    end
endmodule

// File: rtl/mw_word_reader.sv
module mw_word_reader
    import mw_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int HOLD_CYCLES = 50
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              ee_cs_o,
    output logic              ee_sk_o,
    output logic              ee_di_o,
    input  logic              ee_do_i
);
    localparam int N_STEPS = 15 + 2 * ADDR_W + 2 * DATA_W;
    localparam int STEP_W  = $clog2(N_STEPS + 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEPS - 1);

    typedef struct packed {
        mw_state_e         st;
        logic [STEP_W-1:0] step;
        logic [ADDR_W-1:0] addr;
        mw_pins_t          pins;
        logic [DATA_W-1:0] shift;
        logic [DATA_W-1:0] data;
        logic              done;
    } reader_t;

    reader_t r_d, r_q;

    logic              load;
    logic              expire;
    logic              dq_sync;
    logic              cur_sample;
    mw_pins_t          nxt_pins;
    mw_pins_t          unused_cur_pins;
    logic              unused_nxt_sample;
    logic [STEP_W-1:0] step_nxt;

    assign step_nxt = r_q.step + STEP_W'(1);

    mw_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (load),
        .expire_o (expire)
    );

    mw_sync2 u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (ee_do_i),
        .q_o    (dq_sync)
    );

    mw_step_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_W(STEP_W)) u_dec_cur (
        .step_i   (r_q.step),
        .addr_i   (r_q.addr),
        .pins_o   (unused_cur_pins),
        .sample_o (cur_sample)
    );

    mw_step_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_W(STEP_W)) u_dec_nxt (
        .step_i   (step_nxt),
        .addr_i   (r_q.addr),
        .pins_o   (nxt_pins),
        .sample_o (unused_nxt_sample)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        load     = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    r_d.st    = ST_RUN;
                    r_d.step  = '0;
                    r_d.addr  = addr_i;
                    r_d.pins  = '0;
                    r_d.shift = '0;
                    load      = 1'b1;
                end
            end
            default: begin
                if (expire) begin
                    if (cur_sample) begin
                        r_d.shift = {r_q.shift[DATA_W-2:0], dq_sync};
                    end
                    if (r_q.step == LAST_STEP) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                        r_d.data = r_q.shift;
                        r_d.pins = '0;
                    end else begin
                        r_d.step = step_nxt;
                        r_d.pins = nxt_pins;
                        load     = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o  = (r_q.st == ST_RUN);
    assign done_o  = r_q.done;
    assign data_o  = r_q.data;
    assign ee_cs_o = r_q.pins.cs;
    assign ee_sk_o = r_q.pins.sk;
    assign ee_di_o = r_q.pins.di;
endmodule

// File: rtl/mw_word_reader_chk.sv
module mw_word_reader_chk #(
    parameter int HOLD_CYCLES = 50
) (
    input logic clk_i,
    input logic rst_ni,
    input logic req_i,
    input logic busy_o,
    input logic done_o,
    input logic ee_cs_o,
    input logic ee_sk_o,
    input logic ee_di_o
);
    logic [2:0] pins_now;
    logic [2:0] pins_prev;
    int         held;

    assign pins_now = {ee_cs_o, ee_sk_o, ee_di_o};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pins_prev <= '0;
            held      <= 0;
        end else begin
            pins_prev <= pins_now;
            if (pins_now != pins_prev) begin
                held <= 0;
            end else if (held < HOLD_CYCLES) begin
                held <= held + 1;
            end
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (pins_now == 3'b000));

    p_hold_time_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pins_now != pins_prev) |-> (held >= HOLD_CYCLES - 1));

    p_di_needs_cs_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ee_di_o |-> ee_cs_o);

    p_di_steady_clk_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ee_sk_o && $past(ee_sk_o)) |-> $stable(ee_di_o));

    p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    p_done_closes_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy_o && $past(busy_o)));

    p_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && req_i) |=> busy_o);

    p_busy_until_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> (busy_o || done_o));
endmodule

bind mw_word_reader mw_word_reader_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .ee_cs_o (ee_cs_o),
    .ee_sk_o (ee_sk_o),
    .ee_di_o (ee_di_o)
);

// File: tb/mw_word_reader_bench.sv
module mw_word_reader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 4;
    localparam int NSTEP      = 63;

    localparam logic [2:0] PS = 3'b100;
    localparam logic [2:0] PC = 3'b010;
    localparam logic [2:0] PD = 3'b001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [7:0]  addr = '0;
    logic        busy, done;
    logic [15:0] data;
    logic        cs, sk, di;
    logic        eedo = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [2:0] exp_pins [1:NSTEP];
    int         exp_n;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mw_word_reader #(.ADDR_W(8), .DATA_W(16), .HOLD_CYCLES(H)) u_mw_word_reader (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .req_i   (req),
        .addr_i  (addr),
        .busy_o  (busy),
        .done_o  (done),
        .data_o  (data),
        .ee_cs_o (cs),
        .ee_sk_o (sk),
        .ee_di_o (di),
        .ee_do_i (eedo)
    );

    function automatic logic [15:0] word_of(input logic [7:0] a);
        logic [15:0] w;
        w = 16'(a * 16'h02D1) ^ {a, ~a} ^ 16'h6C3A;
        return w;
    endfunction

    // behavioural EEPROM responder
    int          rp_phase = 0;
    int          rp_cnt = 0;
    logic [1:0]  rp_op = '0;
    logic [7:0]  rp_addr = '0;
    logic [15:0] rp_word = '0;

    always @(negedge cs) begin
        rp_phase = 0;
        rp_cnt   = 0;
    end

    always @(posedge sk) begin
        if (cs) begin
            case (rp_phase)
                0: if (di) begin rp_phase = 1; rp_cnt = 0; end
                1: begin
                    rp_op = {rp_op[0], di};
                    rp_cnt++;
                    if (rp_cnt == 2) begin rp_phase = 2; rp_cnt = 0; end
                end
                2: begin
                    rp_addr = {rp_addr[6:0], di};
                    rp_cnt++;
                    if (rp_cnt == 8) begin
                        rp_phase = (rp_op == 2'b10) ? 3 : 4;
                        rp_cnt   = 0;
                        rp_word  = word_of(rp_addr);
                    end
                end
                3: begin
                    if (rp_cnt < 16) eedo <= rp_word[15 - rp_cnt];
                    else             eedo <= 1'b0;
                    rp_cnt++;
                end
                default: ;
            endcase
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected under 190000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req_tag, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req_tag, act, expv);
        end
    endtask

    task automatic push(input logic [2:0] p);
        exp_n++;
        exp_pins[exp_n] = p;
    endtask

    task automatic build_exp(input logic [7:0] a);
        exp_n = 0;
        push(PS); push(PS | PC); push(PS);
        push(PS | PD); push(PS | PD | PC);
        push(PS | PD); push(PS | PD | PC);
        push(PS); push(PS | PC);
        for (int b = 7; b >= 0; b--) begin
            push(PS | (a[b] ? PD : 3'b000));
            push(PS | PC | (a[b] ? PD : 3'b000));
        end
        push(PS);
        for (int q = 0; q < 16; q++) begin
            push(PS | PC);
            push(PS);
        end
        push(3'b000); push(PS); push(3'b000); push(PC);
        push(3'b000);
    endtask

    function automatic string tag_of(input int k);
        if (k <= 3)  return "R3";
        if (k <= 9)  return "R4";
        if (k <= 25) return "R5";
        if (k == 26) return "R6";
        if (k <= 58) return "R7";
        return "R8";
    endfunction

    task automatic do_read(input logic [7:0] a, input bit inject);
        int         c;
        int         nchg;
        bit         fin;
        logic [2:0] prev;
        logic [2:0] cur;
        build_exp(a);
        @(negedge clk);
        req  = 1'b1;
        addr = a;
        c    = 0;
        nchg = 0;
        fin  = 0;
        prev = {cs, sk, di};
        while (!fin) begin
            @(negedge clk);
            c++;
            if (c == 1) begin
                req = 1'b0;
                check(busy == 1'b1, "R9 busy after accept", 32'(busy), 32'd1);
            end
            if (inject && c == 100) begin
                req  = 1'b1;
                addr = ~a;
            end
            if (inject && c == 101) req = 1'b0;
            cur = {cs, sk, di};
            if (cur != prev) begin
                nchg++;
                if (nchg <= NSTEP) begin
                    check(cur == exp_pins[nchg], tag_of(nchg), 32'(cur), 32'(exp_pins[nchg]));
                    check(c == nchg * H + 1, "R2 hold", 32'(c), 32'(nchg * H + 1));
                end
                prev = cur;
            end
            if (done) begin
                fin = 1;
                check(c == NSTEP * H + 1, "R9 done timing", 32'(c), 32'(NSTEP * H + 1));
                check(busy == 1'b0, "R9 busy falls with done", 32'(busy), 32'd0);
                check(data == word_of(a), inject ? "R10 result kept" : "R7 data",
                      32'(data), 32'(word_of(a)));
            end else if (c > 2000) begin
                fin = 1;
                check(1'b0, "R9 timeout", 32'(c), 32'(NSTEP * H + 1));
            end
        end
        check(nchg == NSTEP, "R8 change count", 32'(nchg), 32'(NSTEP));
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, inject ? "R10 no second read" : "R9 idle after done",
              32'({busy, done}), 32'd0);
        check({cs, sk, di} == 3'b000, "R1 idle pins", 32'({cs, sk, di}), 32'd0);
        check(data == word_of(a), "R1 data held", 32'(data), 32'(word_of(a)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({cs, sk, di} == 3'b000, "R1 reset pins", 32'({cs, sk, di}), 32'd0);
        check(busy == 1'b0 && done == 1'b0, "R1 reset flags", 32'({busy, done}), 32'd0);
        check(data == 16'h0000, "R1 reset data", 32'(data), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(busy == 1'b0, "R1 idle without request", 32'(busy), 32'd0);
        for (int a = 0; a < 256; a++) begin
            do_read(8'(a), (a % 37) == 3);
        end
        do_read(8'hFF, 1'b1);
        do_read(8'h00, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule